// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches one asynchronous external interrupt pin and turns its activity into an interrupt request for the core. The pin passes through a synchronizer. A 2-bit sense code then chooses what counts as activity: a low level, any change, a falling edge or a rising edge. In the three edge codes, a detected event sets a sticky pending flag, and an acknowledge from the core clears it. In the low-level code there is no flag. The request follows the synchronized pin directly.

The request reaches the core only while both the global interrupt enable and the pin's own mask bit are 1. Edge events are taken only while the mask is 1. Software that rewrites the sense code should therefore clear the mask first. The detector compares a mode-dependent trigger value against its value one cycle earlier, so switching codes with the mask set can create a false event. This behaviour is deliberate. A read view of the control field returns the sense code with the reserved bit above it forced to 0.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, irq_req and edge_flag are 0. The synchronizer and the stored trigger are preset so that no event is seen in the first cycles after reset.
- R2: With sense code 2'b00 (low level), irq_req is 1 exactly while the synchronized pin is 0. The request appears on the second clock edge after the pin falls and drops on the second edge after it rises. edge_flag is never set in this code.
- R3: With sense code 2'b01, every change of the synchronized pin sets edge_flag on the third clock edge after the pin changes.
- R4: With sense code 2'b10, a 1-to-0 transition of the pin sets edge_flag on the third edge, and a 0-to-1 transition does not set it.
- R5: With sense code 2'b11, a 0-to-1 transition sets edge_flag on the third edge, and a 1-to-0 transition does not set it.
- R6: irq_req is 1 only when global_en and pin_mask are both 1. In an edge code, irq_req equals global_en & pin_mask & edge_flag. A flag set while global_en is 0 stays pending and raises irq_req once global_en returns to 1.
- R7: irq_ack = 1 clears edge_flag on the next edge. If an event is taken on that same edge, the set wins.
- R8: An edge event that occurs while pin_mask is 0 is dropped. No flag is set, and no request follows when the mask is later set.
- R9: With pin_mask = 1, changing the sense code from 2'b10 to 2'b11 while the pin is steadily high sets edge_flag on the next edge (a false request). Making the same change with pin_mask = 0 leaves edge_flag at 0, and no request appears after the mask is set again.
- R10: ctrl_view[1:0] equals sense_mode, and ctrl_view[2] (the reserved bit) always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous external interrupt pin |
| sense_mode | input | 2 | Sense code: 00 low, 01 any change, 10 falling, 11 rising |
| pin_mask | input | 1 | Mask bit of this interrupt source |
| global_en | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Acknowledge; clears the pending flag |
| irq_req | output | 1 | Interrupt request to the core |
| edge_flag | output | 1 | Sticky pending flag for the edge codes |
| ctrl_view | output | 3 | Read view: {reserved 0, sense code} |

## Verification
On every cycle, the embedded properties check several invariants. The request is never raised without both enables. A level-code request always matches a low synchronized pin. An edge-code request always stands on the flag. A pending flag survives until it is acknowledged, and the flag only rises when the mask was set. The exact latencies through the synchronizer and the directional selectivity of each edge code can only be shown by the bench's scenarios. The same holds for the false event caused by a code change and its suppression when the mask is cleared, which the bench checks both with directed sequences and against a cycle model driven by random pin, mask, enable, acknowledge and mode traffic.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_raw,
  input  logic [1:0] sense_mode,
  input  logic       pin_mask,
  input  logic       global_en,
  input  logic       irq_ack,
  output logic       irq_req,
  output logic       edge_flag,
  output logic [2:0] ctrl_view
);

  localparam logic [1:0] SENSE_LOW  = 2'b00;
  localparam logic [1:0] SENSE_ANY  = 2'b01;
  localparam logic [1:0] SENSE_FALL = 2'b10;
  localparam logic [1:0] SENSE_RISE = 2'b11;

  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_s, pin_d;
  logic trig, trig_d;
  logic hit;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};

  assign pin_s = sync_q[SYNC_STAGES-1];

  // trigger polarity follows the current code; a code change can look like an edge
  assign trig = (sense_mode == SENSE_RISE || sense_mode == SENSE_ANY) ? pin_s : ~pin_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_d  <= 1'b1;
      trig_d <= 1'b1;
    end else begin
      pin_d  <= pin_s;
      trig_d <= trig;
    end

  always_comb
    case (sense_mode)
      SENSE_LOW: hit = 1'b0;
      SENSE_ANY: hit = pin_s ^ pin_d;
      default:   hit = trig & ~trig_d;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 flag_q <= 1'b0;
    else if (hit && pin_mask)   flag_q <= 1'b1;
    else if (irq_ack)           flag_q <= 1'b0;

  assign edge_flag = flag_q;
  assign irq_req   = global_en & pin_mask & ((sense_mode == SENSE_LOW) ? ~pin_s : flag_q);
  assign ctrl_view = {1'b0, sense_mode};

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (global_en && pin_mask)); // R6

  AST_LEVEL_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && sense_mode == SENSE_LOW) |-> !sync_q[SYNC_STAGES-1]); // R2

  AST_EDGE_REQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && sense_mode != SENSE_LOW) |-> edge_flag); // R6

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag && !irq_ack) |=> edge_flag); // R7

  AST_FLAG_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_flag) |-> $past(pin_mask)); // R8

endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
  logic clk = 0, rst_n = 0;
  logic pin_raw = 1, pin_mask = 0, global_en = 0, irq_ack = 0;
  logic [1:0] sense_mode = 2'b10;
  logic irq_req, edge_flag;
  logic [2:0] ctrl_view;
  int checks = 0, errors = 0;
  bit use_model = 0;

  always #2 clk = ~clk;

  ext_irq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .sense_mode(sense_mode),
    .pin_mask(pin_mask), .global_en(global_en), .irq_ack(irq_ack),
    .irq_req(irq_req), .edge_flag(edge_flag), .ctrl_view(ctrl_view));

  // reference model from the requirements
  logic m1, m2, md, mt, mflag;

  function automatic logic trig_f(input logic [1:0] m, input logic s);
    return (m == 2'b11 || m == 2'b01) ? s : ~s;
  endfunction

  function automatic logic hit_f(input logic [1:0] m, input logic s, input logic d, input logic t);
    if (m == 2'b00) return 1'b0;
    if (m == 2'b01) return s ^ d;
    return trig_f(m, s) & ~t;
  endfunction

  function automatic logic req_f(input logic [1:0] m, input logic s, input logic f,
                                 input logic g, input logic k);
    return g & k & ((m == 2'b00) ? ~s : f);
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1 <= 1; m2 <= 1; md <= 1; mt <= 1; mflag <= 0;
    end else begin
      m1 <= pin_raw; m2 <= m1; md <= m2; mt <= trig_f(sense_mode, m2);
      if (hit_f(sense_mode, m2, md, mt) && pin_mask) mflag <= 1;
      else if (irq_ack) mflag <= 0;
    end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic clear_flag();
    irq_ack = 1; tick(); irq_ack = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    tick(2);
    chk(irq_req, 0, "R1 req after reset");
    chk(edge_flag, 0, "R1 flag after reset");
    rst_n = 1;
    tick(3);
    chk(edge_flag, 0, "R1 no event after reset");

    // R10 readback
    for (int m = 0; m < 4; m++) begin
      sense_mode = 2'(m); #1;
      chk(ctrl_view[2], 0, "R10 reserved bit");
      chk(ctrl_view[1:0] == 2'(m), 1, "R10 code echo");
    end

    // R2 low level
    pin_mask = 0; sense_mode = 2'b00; global_en = 1; pin_mask = 1; tick(3);
    pin_raw = 0; tick();
    chk(irq_req, 0, "R2 not yet after one edge");
    tick();
    chk(irq_req, 1, "R2 request after two edges");
    pin_raw = 1; tick();
    chk(irq_req, 1, "R2 still low in sync");
    tick();
    chk(irq_req, 0, "R2 request drops");
    chk(edge_flag, 0, "R2 no flag in level code");

    // R4 falling
    pin_mask = 0; sense_mode = 2'b10; tick(2); clear_flag(); pin_mask = 1;
    pin_raw = 0; tick(2);
    chk(edge_flag, 0, "R4 flag not before third edge");
    tick();
    chk(edge_flag, 1, "R4 falling sets flag");
    chk(irq_req, 1, "R6 edge request");
    global_en = 0; #1;
    chk(irq_req, 0, "R6 gated by global enable");
    tick(3);
    chk(edge_flag, 1, "R6 flag pending");
    global_en = 1; #1;
    chk(irq_req, 1, "R6 pending request raised");
    clear_flag();
    chk(edge_flag, 0, "R7 ack clears");
    pin_raw = 1; tick(4);
    chk(edge_flag, 0, "R4 rising ignored");

    // R5 rising
    pin_mask = 0; sense_mode = 2'b11; tick(2); clear_flag(); pin_mask = 1;
    pin_raw = 0; tick(4);
    chk(edge_flag, 0, "R5 falling ignored");
    pin_raw = 1; tick(3);
    chk(edge_flag, 1, "R5 rising sets flag");

    // R3 any change
    pin_mask = 0; sense_mode = 2'b01; tick(2); clear_flag(); pin_mask = 1;
    pin_raw = 0; tick(3);
    chk(edge_flag, 1, "R3 fall sets flag");
    clear_flag(); tick(2);
    pin_raw = 1; tick(2);
    chk(edge_flag, 0, "R3 not before third edge");
    tick();
    chk(edge_flag, 1, "R3 rise sets flag");

    // R7 simultaneous ack and event: set wins
    clear_flag();
    pin_raw = 0; tick(2); irq_ack = 1; tick(); irq_ack = 0;
    chk(edge_flag, 1, "R7 set wins over ack");

    // R8 masked event dropped
    clear_flag(); pin_mask = 0;
    pin_raw = 1; tick(4);
    pin_mask = 1; #1;
    chk(edge_flag, 0, "R8 masked event dropped");
    chk(irq_req, 0, "R8 no request after unmask");

    // R9 false request on code change
    sense_mode = 2'b10; tick(3); clear_flag(); tick();
    sense_mode = 2'b11; tick();
    chk(edge_flag, 1, "R9 false event with mask set");
    pin_mask = 0; sense_mode = 2'b10; tick(2); clear_flag(); tick();
    sense_mode = 2'b11; tick(3);
    pin_mask = 1; #1;
    chk(edge_flag, 0, "R9 no flag with mask cleared");
    chk(irq_req, 0, "R9 no request with mask cleared");

    // random traffic against the model
    void'($urandom(32'h1234_5678));
    use_model = 1;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 3) == 0) pin_raw = ~pin_raw;
      if ($urandom_range(0, 7) == 0) pin_mask = ~pin_mask;
      if ($urandom_range(0, 7) == 0) global_en = ~global_en;
      irq_ack = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 40) == 0) sense_mode = 2'($urandom_range(0, 3));
      #1;
      chk(edge_flag, mflag, "R3 R4 R5 R7 R8 R9 model flag");
      chk(irq_req, req_f(sense_mode, m2, mflag, global_en, pin_mask), "R2 R6 model request");
      chk(ctrl_view[2], 0, "R10 reserved");
    end
    finish_run();
  end
endmodule